// File: doc/BRIEF.md
# Load-Address Stride Prefetcher

This block watches the stream of load instructions retiring address generation and learns, per load instruction, whether successive addresses move by a fixed distance. Each load's program counter selects one slot of a small direct-mapped history table. The slot keeps a tag drawn from the upper PC bits, the address the load touched last time, the last stride observed and a two-bit confidence state.

On every load the slot checks whether the new address equals the remembered address plus the remembered stride. That outcome moves the slot through four confidence states: fresh, tentative, locked and unpredictable. Once a slot is locked with a nonzero stride, a load that confirms the pattern produces a prefetch request for the next address in the sequence. The request appears one clock after the load and lasts one cycle. It is meant to feed a cache's miss path, which does its own filtering.

Top module: `stride_prefetcher`

## Requirements
- R1: While reset is held and in the first cycle after it, `pf_valid` is low, and every slot starts empty, so the first load of any PC issues no prefetch.
- R2: A load whose slot is empty or holds another tag claims the slot. The slot is set to state fresh, stride 0 and previous address equal to the load address. No prefetch is issued for that load.
- R3: A load that hits its slot counts as correct when `ld_addr` equals the stored previous address plus the stored stride, using modulo 2^ADDR_W arithmetic. On every hit, the previous address becomes `ld_addr`.
- R4: In state fresh, a correct load moves the slot to locked. An incorrect load moves it to tentative and stores `ld_addr` minus the previous address as the new stride.
- R5: In state tentative, a correct load moves the slot to locked. An incorrect load moves it to unpredictable and stores the new difference as the stride.
- R6: In state locked, a correct load keeps the slot locked. An incorrect load returns it to fresh and keeps the old stride.
- R7: In state unpredictable, a correct load moves the slot to tentative. An incorrect load keeps it unpredictable and stores the new difference as the stride.
- R8: A prefetch is issued one clock after a hitting load exactly when that load leaves the slot locked with a nonzero stride. `pf_addr` is then `ld_addr` plus the stride.
- R9: The table holds ENTRIES slots, indexed by `ld_pc[WORD_OFF +: log2(ENTRIES)]` (bits 5:2 with the defaults). Two PCs that share an index but differ in the upper bits evict each other. PCs with different indexes keep independent state.
- R10: `pf_valid` is high only in the cycle right after a cycle with `ld_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | A load is presented this cycle |
| ld_pc | input | PC_W | Program counter of the load |
| ld_addr | input | ADDR_W | Data address of the load |
| pf_valid | output | 1 | Prefetch request valid (one cycle) |
| pf_addr | output | ADDR_W | Prefetch target address |

## Verification
A corrupted confidence state or stride is only visible at the ports through the presence, absence or value of `pf_valid`/`pf_addr` on a later load of the same PC. A wrong state can therefore remain hidden for up to two further loads of that PC before it produces a missing or extra prefetch. The directed sequences lead each slot through every transition and then add a confirming load whose prefetch outcome reveals the state reached and the stride stored. Eviction and stride retention in state locked are each exposed by one follow-up load whose address would prefetch only if the old state had survived.

// File: rtl/stride_prefetcher.sv
module stride_prefetcher #(
  parameter int PC_W     = 32,
  parameter int ADDR_W   = 32,
  parameter int ENTRIES  = 16,
  parameter int WORD_OFF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [PC_W-1:0]   ld_pc,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W - WORD_OFF;

  typedef enum logic [1:0] {S_FRESH, S_TENT, S_LOCK, S_UNPRED} conf_t;

  logic              vld_q    [ENTRIES];
  logic [TAG_W-1:0]  tag_q    [ENTRIES];
  logic [ADDR_W-1:0] prev_q   [ENTRIES];
  logic [ADDR_W-1:0] stride_q [ENTRIES];
  conf_t             st_q     [ENTRIES];

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag_in;
  logic              hit, match;
  logic [ADDR_W-1:0] diff, stride_nxt;
  conf_t             st_nxt;

  assign idx    = ld_pc[WORD_OFF +: IDX_W];
  assign tag_in = ld_pc[PC_W-1 -: TAG_W];
  assign hit    = vld_q[idx] && (tag_q[idx] == tag_in);
  assign diff   = ld_addr - prev_q[idx];
  assign match  = (diff == stride_q[idx]);

  always_comb begin
    st_nxt     = st_q[idx];
    stride_nxt = stride_q[idx];
    unique case (st_q[idx])
      S_FRESH:  if (match) st_nxt = S_LOCK;
                else begin st_nxt = S_TENT;   stride_nxt = diff; end
      S_TENT:   if (match) st_nxt = S_LOCK;
                else begin st_nxt = S_UNPRED; stride_nxt = diff; end
      S_LOCK:   if (!match) st_nxt = S_FRESH;
      S_UNPRED: if (match) st_nxt = S_TENT;
                else stride_nxt = diff;
      default:  st_nxt = S_FRESH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        vld_q[i] <= 1'b0;
        st_q[i]  <= S_FRESH;
      end
      pf_valid <= 1'b0;
      pf_addr  <= '0;
    end else begin
      pf_valid <= 1'b0;
      if (ld_valid) begin
        prev_q[idx] <= ld_addr;
        if (hit) begin
          st_q[idx]     <= st_nxt;
          stride_q[idx] <= stride_nxt;
          if (st_nxt == S_LOCK && stride_nxt != '0) begin
            pf_valid <= 1'b1;
            pf_addr  <= ld_addr + stride_nxt;
          end
        end else begin
          vld_q[idx]    <= 1'b1;
          tag_q[idx]    <= tag_in;
          st_q[idx]     <= S_FRESH;
          stride_q[idx] <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/stride_prefetcher_chk.sv
module stride_prefetcher_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_valid,
  input logic              hit,
  input logic [ADDR_W-1:0] ld_addr,
  input logic              pf_valid,
  input logic [ADDR_W-1:0] pf_addr
);
  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !pf_valid);
  a_r2_miss_no_pf: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !hit) |=> !pf_valid);
  a_r10_pf_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> $past(ld_valid));
  a_r8_nonzero_stride: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (pf_addr != $past(ld_addr)));
  a_r8_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> $past(hit));
endmodule

bind stride_prefetcher stride_prefetcher_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .hit(hit),
  .ld_addr(ld_addr), .pf_valid(pf_valid), .pf_addr(pf_addr)
);

// File: tb/stride_prefetcher_tb.sv
module stride_prefetcher_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic [31:0] ld_pc = '0;
  logic [31:0] ld_addr = '0;
  logic        pf_valid;
  logic [31:0] pf_addr;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  stride_prefetcher u_dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_pc(ld_pc),
    .ld_addr(ld_addr), .pf_valid(pf_valid), .pf_addr(pf_addr)
  );

  task automatic chk(input string req, input logic ev, input logic [31:0] ea);
    total++;
    if (pf_valid !== ev || (ev && pf_addr !== ea)) begin
      bad++;
      $display("FAIL %s: got v=%0b a=%h, expected v=%0b a=%h", req, pf_valid, pf_addr, ev, ea);
    end
  endtask

  task automatic load(input string req, input logic [31:0] pc, input logic [31:0] a,
                      input logic ev, input logic [31:0] ea);
    ld_valid = 1'b1; ld_pc = pc; ld_addr = a;
    @(negedge clk);
    ld_valid = 1'b0;
    chk(req, ev, ea);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 in reset", 1'b0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 1'b0, 0);
  endtask

  task automatic t_train_and_retain;
    load("R2 first load miss",          32'h1004, 32'h100, 1'b0, 0);
    load("R4 fresh wrong to tentative", 32'h1004, 32'h140, 1'b0, 0);
    load("R5 tentative right to locked",32'h1004, 32'h180, 1'b1, 32'h1C0);
    load("R6 locked stays locked",      32'h1004, 32'h1C0, 1'b1, 32'h200);
    @(negedge clk);
    chk("R10 idle cycle no prefetch", 1'b0, 0);
    load("R6 locked wrong to fresh",    32'h1004, 32'h300, 1'b0, 0);
    load("R6 stride kept, fresh right", 32'h1004, 32'h340, 1'b1, 32'h380);
  endtask

  task automatic t_unpredictable;
    load("R2 miss",                     32'h1008, 32'h0,  1'b0, 0);
    load("R4 fresh wrong",              32'h1008, 32'h10, 1'b0, 0);
    load("R5 tentative wrong to unpred",32'h1008, 32'h30, 1'b0, 0);
    load("R7 unpred wrong stays",       32'h1008, 32'h60, 1'b0, 0);
    load("R7 unpred right to tentative",32'h1008, 32'h90, 1'b0, 0);
    load("R5 tentative right to locked",32'h1008, 32'hC0, 1'b1, 32'hF0);
  endtask

  task automatic t_zero_and_negative;
    load("R2 miss",                   32'h1010, 32'h500, 1'b0, 0);
    load("R8 zero stride locked",     32'h1010, 32'h500, 1'b0, 0);
    load("R8 zero stride no prefetch",32'h1010, 32'h500, 1'b0, 0);
    load("R2 miss",                   32'h1014, 32'h1000, 1'b0, 0);
    load("R3 negative diff learned",  32'h1014, 32'h0FF0, 1'b0, 0);
    load("R8 negative stride prefetch",32'h1014, 32'h0FE0, 1'b1, 32'h0FD0);
  endtask

  task automatic t_conflict;
    load("R9 other tag same index evicts", 32'h2004, 32'h9000, 1'b0, 0);
    load("R9 evicted pc misses",           32'h1004, 32'h380,  1'b0, 0);
    load("R9 fresh after reclaim",         32'h1004, 32'h380,  1'b0, 0);
    load("R9 other index kept",            32'h1008, 32'hF0,   1'b1, 32'h120);
    load("R3 wrap modulo",                 32'h1014, 32'h0FD0, 1'b1, 32'h0FC0);
  endtask

  initial begin
    t_reset();
    t_train_and_retain();
    t_unpredictable();
    t_zero_and_negative();
    t_conflict();
    @(negedge clk);
    chk("R10 final idle", 1'b0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog: got hung, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule